// File: doc/BRIEF.md
# Masked Level Interrupt Collector

This block gathers a set of level-sensitive interrupt request lines from peripherals on a local bus and presents them to a processor as one combined interrupt. On every clock a source register copies the current levels of the request lines. A writable enable mask gates the source register. The combined output is high whenever any enabled source is high.

Software services the interrupt through a small register window with 16-bit registers. A halfword read of the vector register returns an encoded vector for the lowest-numbered line that is both pending and enabled. The vector is the line number plus one, shifted left by two bits, so it can index a table of word-sized entries directly. The read returns zero when no enabled line is pending. The enable mask sits at the next halfword. The bus accepts byte, halfword and word accesses. A byte write merges into one lane of the mask. A word access is handled as two halfword accesses, low half first, in a single cycle.

Top module: `lbirq_ctrl`

## Requirements
- R1: Each source bit takes the level of its request line on every rising clock edge, so a line that goes high sets its bit and a line that goes low clears it one cycle later.
- R2: `irqOut` is high exactly when the source register ANDed with the low N_LINES bits of the mask is non-zero. It changes one cycle after a request line changes or a mask write is accepted.
- R3: A halfword read (`busSize` = 2'b01) at address 0x000 returns ((i + 1) << 2) in the same cycle, where i is the lowest-numbered bit set in source AND mask. It returns 0 when that AND is zero.
- R4: Address 0x002 holds the 16-bit enable mask. A halfword write there stores `busWrData[15:0]` at the next rising edge, and a halfword read returns the stored mask in bits 15:0.
- R5: While `rstN` is low and right after it is released, the mask is 0x0010, the source is 0 and `irqOut` is low.
- R6: For a byte access (`busSize` = 2'b00), `busAddr[0]` picks the lane: 0 for mask bits 7:0 and 1 for mask bits 15:8. A byte write takes its value from `busWrData[7:0]` and leaves the other byte unchanged. A byte read returns the selected byte zero-extended.
- R7: For a word access (`busSize` = 2'b10), bits 15:0 correspond to the register at the halfword address and bits 31:16 to the register two bytes above it. This holds for reads and writes alike.
- R8: Reads of any address other than 0x000 and 0x002 return 0, and writes to them are ignored. Writes to 0x000 are ignored. `busSize` = 2'b11 is no access at all. `busRdData` is 0 whenever no read is in progress.
- R9: Reads have no side effects: the mask and `irqOut` are the same before and after any read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | N_LINES | Level-sensitive interrupt requests |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | 00 byte, 01 halfword, 10 word, 11 none |
| busAddr | input | ADDR_W | Byte address within the window |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid in the access cycle |
| irqOut | output | 1 | Combined masked interrupt |

## Verification
Read data is combinational from the registers, so each read is sampled 1 ns after the falling edge that drives it, still inside the same cycle. A change on a request line or a mask write passes through exactly one register before it reaches `irqOut` or the vector. The bench therefore drives these at one falling edge and checks them at the next falling edge, after a single rising edge has passed. The sweeps cover every single-line and single-mask-bit pairing, plus pseudo-random multi-bit patterns whose expected vector is computed in the bench.

// File: rtl/lbirq_pkg.sv
package lbirq_pkg;
  localparam int REG_W = 16;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_NONE = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    RG_NONE = 2'b00,
    RG_VEC  = 2'b01,
    RG_MASK = 2'b10
  } reg_sel_e;

  typedef enum logic [1:0] {
    WD_LOW  = 2'b00,
    WD_HIGH = 2'b01,
    WD_BYTE = 2'b10
  } wr_src_e;

  // Strobes from the access decoder to the datapath
  typedef struct packed {
    logic [1:0] maskBe;
    wr_src_e    maskSrc;
    reg_sel_e   rdLo;
    reg_sel_e   rdHi;
    logic       rdByte;
    logic       rdByteHi;
  } strobe_t;
endpackage

// File: rtl/lbirq_ctl.sv
module lbirq_ctl
  import lbirq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int VEC_OFS  = 0,
  parameter int MASK_OFS = 2
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] halfAddr0;
  logic [EXT_W-1:0] halfAddr1;
  reg_sel_e         reg0;
  reg_sel_e         reg1;
  acc_size_e        accSize;

  function automatic reg_sel_e regOf(input logic [EXT_W-1:0] a);
    if (a == EXT_W'(VEC_OFS))       return RG_VEC;
    else if (a == EXT_W'(MASK_OFS)) return RG_MASK;
    else                            return RG_NONE;
  endfunction

  // The extra address bit keeps the second half of a word at the top of
  // the window from wrapping back onto offset zero.
  assign halfAddr0 = {1'b0, busAddr[ADDR_W-1:1], 1'b0};
  assign halfAddr1 = halfAddr0 + EXT_W'(2);
  assign reg0      = regOf(halfAddr0);
  assign reg1      = regOf(halfAddr1);
  assign accSize   = acc_size_e'(busSize);

  always_comb begin
    stb = '0;
    if (busSel) begin
      if (busWr) begin
        case (accSize)
          SZ_BYTE: if (reg0 == RG_MASK) begin
            stb.maskBe  = busAddr[0] ? 2'b10 : 2'b01;
            stb.maskSrc = WD_BYTE;
          end
          SZ_HALF: if (reg0 == RG_MASK) begin
            stb.maskBe  = 2'b11;
            stb.maskSrc = WD_LOW;
          end
          SZ_WORD: begin
            if (reg0 == RG_MASK) begin
              stb.maskBe  = 2'b11;
              stb.maskSrc = WD_LOW;
            end else if (reg1 == RG_MASK) begin
              stb.maskBe  = 2'b11;
              stb.maskSrc = WD_HIGH;
            end
          end
          default: ;
        endcase
      end else begin
        case (accSize)
          SZ_BYTE: begin
            stb.rdLo     = reg0;
            stb.rdByte   = 1'b1;
            stb.rdByteHi = busAddr[0];
          end
          SZ_HALF: stb.rdLo = reg0;
          SZ_WORD: begin
            stb.rdLo = reg0;
            stb.rdHi = reg1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lbirq_dp.sv
module lbirq_dp
  import lbirq_pkg::*;
#(
  parameter int                N_LINES  = 16,
  parameter logic [REG_W-1:0]  MASK_RST = 16'h0010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_LINES-1:0] irqLines,
  input  strobe_t            stb,
  input  logic [BUS_W-1:0]   wrData,
  output logic [BUS_W-1:0]   rdData,
  output logic               irqOut,
  output logic [N_LINES-1:0] srcVec,
  output logic [REG_W-1:0]   maskVec
);
  localparam int N_BYTES = REG_W / 8;

  logic [N_LINES-1:0] srcQ;
  logic [REG_W-1:0]   maskQ;
  logic [N_LINES-1:0] pending;
  logic [REG_W-1:0]   vecVal;
  logic [REG_W-1:0]   wrHalf;
  logic [REG_W-1:0]   rdLoVal;
  logic [REG_W-1:0]   rdHiVal;

  always_ff @(posedge clk) begin
    if (!rstN) srcQ <= '0;
    else       srcQ <= irqLines;
  end

  always_comb begin
    case (stb.maskSrc)
      WD_LOW:  wrHalf = wrData[REG_W-1:0];
      WD_HIGH: wrHalf = wrData[2*REG_W-1:REG_W];
      default: wrHalf = {N_BYTES{wrData[7:0]}};
    endcase
  end

  for (genvar b = 0; b < N_BYTES; b++) begin : g_maskByte
    always_ff @(posedge clk) begin
      if (!rstN)             maskQ[8*b +: 8] <= MASK_RST[8*b +: 8];
      else if (stb.maskBe[b]) maskQ[8*b +: 8] <= wrHalf[8*b +: 8];
    end
  end

  assign pending = srcQ & maskQ[N_LINES-1:0];
  assign irqOut  = |pending;

  // Lowest-numbered pending line wins
  always_comb begin
    vecVal = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (pending[i]) vecVal = REG_W'((i + 1) << 2);
    end
  end

  function automatic logic [REG_W-1:0] valOf(input reg_sel_e s);
    case (s)
      RG_VEC:  return vecVal;
      RG_MASK: return maskQ;
      default: return '0;
    endcase
  endfunction

  assign rdLoVal = valOf(stb.rdLo);
  assign rdHiVal = valOf(stb.rdHi);

  always_comb begin
    if (stb.rdByte)
      rdData = {{(BUS_W-8){1'b0}}, stb.rdByteHi ? rdLoVal[15:8] : rdLoVal[7:0]};
    else
      rdData = {rdHiVal, rdLoVal};
  end

  assign srcVec  = srcQ;
  assign maskVec = maskQ;
endmodule

// File: rtl/lbirq_ctrl.sv
module lbirq_ctrl
  import lbirq_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_LINES-1:0] irqLines,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [1:0]         busSize,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic               irqOut
);
  strobe_t            stb;
  logic [N_LINES-1:0] srcVec;
  logic [REG_W-1:0]   maskVec;

  lbirq_ctl #(.ADDR_W(ADDR_W), .VEC_OFS(0), .MASK_OFS(2)) u_ctl (
    .busSel (busSel),
    .busWr  (busWr),
    .busSize(busSize),
    .busAddr(busAddr),
    .stb    (stb)
  );

  lbirq_dp #(.N_LINES(N_LINES), .MASK_RST(16'h0010)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .irqLines(irqLines),
    .stb     (stb),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .irqOut  (irqOut),
    .srcVec  (srcVec),
    .maskVec (maskVec)
  );
endmodule

// File: rtl/lbirq_chk.sv
module lbirq_chk #(
  parameter int N_LINES = 16,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic [N_LINES-1:0] irqLines,
  input logic               busSel,
  input logic               busWr,
  input logic [1:0]         busSize,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [31:0]        busRdData,
  input logic               irqOut,
  input logic [N_LINES-1:0] srcVec,
  input logic [15:0]        maskVec
);
  p_src_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> srcVec == $past(irqLines));

  p_irq_combine_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (|(srcVec & maskVec[N_LINES-1:0])));

  p_vec_shape_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busSize == 2'b01 && busAddr == '0) |->
      (irqOut ? (busRdData != 32'd0 && busRdData[1:0] == 2'b00) : busRdData == 32'd0));

  p_reset_state_r5: assert property (@(posedge clk)
    $rose(rstN) |-> (maskVec == 16'h0010 && srcVec == '0 && !irqOut));

  p_idle_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWr) |-> busRdData == 32'd0);

  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr) |=> $stable(maskVec));
endmodule

bind lbirq_ctrl lbirq_chk #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irqLines (irqLines),
  .busSel   (busSel),
  .busWr    (busWr),
  .busSize  (busSize),
  .busAddr  (busAddr),
  .busRdData(busRdData),
  .irqOut   (irqOut),
  .srcVec   (srcVec),
  .maskVec  (maskVec)
);

// File: tb/lbirq_ctrl_test.sv
module lbirq_ctrl_test;
  localparam int N = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  irqLines = '0;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic [1:0]    busSize = 2'b01;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic          irqOut;

  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  lbirq_ctrl #(.N_LINES(N), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .busSel(busSel), .busWr(busWr),
    .busSize(busSize), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expVec(input logic [15:0] p);
    for (int i = 0; i < 16; i++) if (p[i]) return 32'((i + 1) * 4);
    return 32'd0;
  endfunction

  task automatic goIdle();
    busSel = 1'b0; busWr = 1'b0; busSize = 2'b01; busAddr = '0; busWrData = '0;
  endtask

  task automatic busWrite(input logic [1:0] sz, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busSize = sz; busAddr = a; busWrData = d;
    @(negedge clk);
    goIdle();
  endtask

  task automatic busRead(input logic [1:0] sz, input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busSize = sz; busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic setLines(input logic [N-1:0] v);
    @(negedge clk);
    goIdle();
    irqLines = v;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] lfA;
    logic [15:0] lfB;
    logic [15:0] m;

    repeat (3) @(negedge clk);
    chk("R5 irqOut in reset", {31'd0, irqOut}, 32'd0);
    rstN = 1'b1;
    irqLines = 16'h0001;
    busRead(2'b01, 12'h002, d); chk("R5 mask reset value", d, 32'h0000_0010);
    busRead(2'b01, 12'h000, d); chk("R5 vector with line 0 masked", d, 32'd0);
    chk("R5 irqOut masked line", {31'd0, irqOut}, 32'd0);
    setLines(16'h0010);
    chk("R2 reset mask enables line 4", {31'd0, irqOut}, 32'd1);
    busRead(2'b01, 12'h000, d); chk("R3 line 4 vector", d, 32'd20);

    busWrite(2'b01, 12'h002, 32'h0000_FFFF);
    busRead(2'b01, 12'h002, d); chk("R4 mask halfword write", d, 32'h0000_FFFF);
    for (int i = 0; i < N; i++) begin
      setLines(16'(1 << i));
      chk("R2 single line raises irqOut", {31'd0, irqOut}, 32'd1);
      busRead(2'b01, 12'h000, d); chk("R3 single line vector", d, 32'((i + 1) << 2));
    end
    setLines(16'h0000);
    chk("R1 lines dropped clear source", {31'd0, irqOut}, 32'd0);
    busRead(2'b01, 12'h000, d); chk("R1 vector after drop", d, 32'd0);

    for (int mb = 0; mb < N; mb++) begin
      busWrite(2'b01, 12'h002, 32'(1 << mb));
      for (int sb = 0; sb < N; sb++) begin
        setLines(16'(1 << sb));
        chk("R2 mask by line sweep", {31'd0, irqOut}, (mb == sb) ? 32'd1 : 32'd0);
        busRead(2'b01, 12'h000, d);
        chk("R3 mask by line vector", d, (mb == sb) ? 32'((sb + 1) << 2) : 32'd0);
      end
    end

    lfA = 16'hACE1; lfB = 16'h1D2B;
    for (int k = 0; k < 300; k++) begin
      lfA = {lfA[14:0], 1'b0} ^ (lfA[15] ? 16'h100B : 16'h0000);
      lfB = {lfB[14:0], 1'b0} ^ (lfB[15] ? 16'h002D : 16'h0000);
      busWrite(2'b01, 12'h002, {16'h0, lfB});
      setLines(lfA);
      chk("R2 random pattern irqOut", {31'd0, irqOut}, {31'd0, |(lfA & lfB)});
      busRead(2'b01, 12'h000, d); chk("R3 random pattern vector", d, expVec(lfA & lfB));
    end

    busWrite(2'b01, 12'h002, 32'h0000_1234);
    busWrite(2'b00, 12'h002, 32'h0000_00AB);
    busRead(2'b01, 12'h002, d); chk("R6 low byte merge", d, 32'h0000_12AB);
    busWrite(2'b00, 12'h003, 32'hFFFF_FFCD);
    busRead(2'b01, 12'h002, d); chk("R6 high byte merge", d, 32'h0000_CDAB);
    busRead(2'b00, 12'h003, d); chk("R6 byte read high lane", d, 32'h0000_00CD);
    busRead(2'b00, 12'h002, d); chk("R6 byte read low lane", d, 32'h0000_00AB);

    busWrite(2'b10, 12'h000, 32'h5A5A_0F0F);
    busRead(2'b01, 12'h002, d); chk("R7 word write at 0 upper half to mask", d, 32'h0000_5A5A);
    busWrite(2'b10, 12'h002, 32'hFFFF_00C3);
    busRead(2'b01, 12'h002, d); chk("R7 word write at 2 lower half to mask", d, 32'h0000_00C3);
    setLines(16'h0180);
    busRead(2'b10, 12'h000, d); chk("R7 word read at 0", d, 32'h00C3_0020);
    busRead(2'b10, 12'h002, d); chk("R7 word read at 2", d, 32'h0000_00C3);

    busWrite(2'b01, 12'h004, 32'h0000_FFFF);
    busWrite(2'b01, 12'h000, 32'h0000_FFFF);
    busWrite(2'b11, 12'h002, 32'h0000_FFFF);
    busRead(2'b01, 12'h002, d); chk("R8 stray writes ignored", d, 32'h0000_00C3);
    busRead(2'b01, 12'h004, d); chk("R8 unmapped read", d, 32'd0);
    busRead(2'b10, 12'hFFE, d); chk("R8 top-of-window word read", d, 32'd0);
    busRead(2'b11, 12'h002, d); chk("R8 no-access size read", d, 32'd0);
    setLines(16'h0180);
    #1 chk("R8 idle read data", busRdData, 32'd0);

    m = 16'h00C3;
    busRead(2'b01, 12'h000, d);
    busRead(2'b01, 12'h000, d); chk("R9 repeated vector read", d, 32'h0000_0020);
    busRead(2'b01, 12'h002, d); chk("R9 mask unchanged by reads", d, {16'h0, m});
    chk("R9 irqOut unchanged by reads", {31'd0, irqOut}, 32'd1);

    busWrite(2'b01, 12'h002, 32'h0000_0000);
    chk("R2 mask write drops irqOut", {31'd0, irqOut}, 32'd0);

    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    busRead(2'b01, 12'h002, d); chk("R5 mask after second reset", d, 32'h0000_0010);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule